// File: doc/BRIEF.md
# I3C Target Address Acknowledge Handoff

This block is the address-phase front end of an I3C target. It oversamples the SCL and SDA pins with a fast system clock, brings both through synchronizers, and detects bus START, repeated START and STOP conditions. After a START it shifts in a 7-bit address followed by the read/write bit. It then decides whether to acknowledge. It acknowledges the broadcast address 7'h7E at all times, and it acknowledges its own dynamic address while that address is flagged valid.

During the ninth (acknowledge) bit the block drives an SDA output enable. The pad turns that enable into an open-drain low. When the transfer is an I3C message and the address is a write, the enable drops as soon as the synchronized SCL is seen rising, so the controller can take over SDA. In legacy I2C mode, and for any read address, the enable stays asserted until SCL falls. The data phase that follows is handled elsewhere, so the block reports only a match flag, the latched read/write flag and an in-message flag.

Top module: `i3c_addr_ack`

## Requirements
- R1: SDA falling while SCL is high (START or repeated START) restarts the address phase, clears `match_o` and sets `in_msg_o`.
- R2: SDA rising while SCL is high (STOP) clears `in_msg_o`, `match_o` and `sda_oe_o`.
- R3: Address bits are sampled MSB first on SCL rising edges. The eighth sampled bit is latched into `rnw_o`, where 1 means read.
- R4: Address 7'h7E is always acknowledged, whatever the dynamic-address inputs are.
- R5: An address equal to `dyn_addr_i` is acknowledged only while `dyn_addr_valid_i` is 1.
- R6: For an address that is not acknowledged, `sda_oe_o` stays 0 for the whole frame. `sda_oe_o` is never 1 during the address bits.
- R7: For an acknowledged address, `sda_oe_o` rises within 4 system clocks after the SCL falling edge that ends the read/write bit, and it stays 1 while SCL is low.
- R8: With `i3c_mode_i` = 1 and a write address, `sda_oe_o` drops within 4 system clocks after SCL rises in the ACK bit.
- R9: With `i3c_mode_i` = 0, an acknowledged `sda_oe_o` stays 1 for the whole SCL high period of the ACK bit.
- R10: For a read address that is acknowledged, `sda_oe_o` stays 1 past the SCL rise of the ACK bit, in either mode.
- R11: While the controller holds SDA low after the ACK-bit SCL rise, the block sees no STOP, and `in_msg_o` stays 1.
- R12: `sda_oe_o` drops within 4 system clocks after the SCL falling edge that ends the ACK bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level (asynchronous) |
| sda_i | input | 1 | SDA pin level (asynchronous) |
| dyn_addr_i | input | 7 | Own dynamic address |
| dyn_addr_valid_i | input | 1 | Own address is assigned and may be matched |
| i3c_mode_i | input | 1 | 1: I3C message handoff, 0: legacy I2C ACK timing |
| sda_oe_o | output | 1 | SDA output enable (1 = pull SDA low) |
| match_o | output | 1 | Last address was acknowledged |
| rnw_o | output | 1 | Latched read/write bit (1 = read) |
| in_msg_o | output | 1 | A message is open (START seen, no STOP yet) |

## Verification
The assertions check on every cycle that the enable is only driven for a matched address, and that START and STOP are never seen together. They also check the cycle-level response to a detected SCL edge in the ACK bit: release for an I3C write, hold for legacy mode and for reads, and release on the falling edge. Which addresses match, the MSB-first bit order, the latency from the pins through the synchronizers, and the fact that the controller's low overlap is not taken as a STOP can only be shown by the bench. It drives whole frames over every address with both directions and both modes, uses repeated STARTs, and checks the dynamic address with its valid flag both set and cleared.

// File: rtl/i3c_ack_pkg.sv
package i3c_ack_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_DRV,
    ST_ACK_HIGH,
    ST_DONE
  } ack_st_e;
endpackage

// File: rtl/i3c_sync.sv
module i3c_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  // bus idles high, so reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i3c_bus_cond.sv
module i3c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edges only count while SCL is high on both samples
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i3c_addr_fsm.sv
module i3c_addr_fsm
  import i3c_ack_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [AW-1:0] dyn_addr_i,
  input  logic          dyn_addr_valid_i,
  input  logic          i3c_mode_i,
  output ack_st_e       st_o,
  output logic          sda_oe_o,
  output logic          match_o,
  output logic          rnw_o,
  output logic          in_msg_o
);
  localparam int unsigned CNT_W = $clog2(AW + 1);

  ack_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    sh_q;
  logic             match_q, rnw_q, in_msg_q;
  logic             hit;

  assign hit = (sh_q == BCAST_ADDR[AW-1:0]) | (dyn_addr_valid_i & (sh_q == dyn_addr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      match_q  <= 1'b0;
      rnw_q    <= 1'b0;
      in_msg_q <= 1'b0;
    end else if (stop_i) begin
      st_q     <= ST_IDLE;
      match_q  <= 1'b0;
      in_msg_q <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_ADDR;
      cnt_q    <= '0;
      match_q  <= 1'b0;
      in_msg_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_ADDR: if (scl_rise_i) begin
          if (cnt_q == CNT_W'(AW)) begin
            rnw_q   <= sda_s_i;
            match_q <= hit;
            st_q    <= ST_ACK_WAIT;
          end else begin
            sh_q  <= {sh_q[AW-2:0], sda_s_i};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACK_WAIT: if (scl_fall_i) st_q <= ST_ACK_DRV;
        ST_ACK_DRV:  if (scl_rise_i) st_q <= ST_ACK_HIGH;
        ST_ACK_HIGH: if (scl_fall_i) st_q <= ST_DONE;
        default: ;
      endcase
    end
  end

  // I3C write hands SDA to the controller on SCL rise; reads and legacy hold to SCL fall
  assign sda_oe_o = match_q & ((st_q == ST_ACK_DRV) |
                               ((st_q == ST_ACK_HIGH) & (rnw_q | ~i3c_mode_i)));
  assign st_o     = st_q;
  assign match_o  = match_q;
  assign rnw_o    = rnw_q;
  assign in_msg_o = in_msg_q;
endmodule

// File: rtl/i3c_addr_ack.sv
module i3c_addr_ack
  import i3c_ack_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dyn_addr_i,
  input  logic              dyn_addr_valid_i,
  input  logic              i3c_mode_i,
  output logic              sda_oe_o,
  output logic              match_o,
  output logic              rnw_o,
  output logic              in_msg_o
);
  logic    scl_s, sda_s;
  logic    scl_rise_w, scl_fall_w, start_w, stop_w;
  ack_st_e st_w;

  i3c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i3c_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise_w),
    .scl_fall_o(scl_fall_w),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  i3c_addr_fsm #(.AW(ADDR_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sda_s_i         (sda_s),
    .scl_rise_i      (scl_rise_w),
    .scl_fall_i      (scl_fall_w),
    .start_i         (start_w),
    .stop_i          (stop_w),
    .dyn_addr_i      (dyn_addr_i),
    .dyn_addr_valid_i(dyn_addr_valid_i),
    .i3c_mode_i      (i3c_mode_i),
    .st_o            (st_w),
    .sda_oe_o        (sda_oe_o),
    .match_o         (match_o),
    .rnw_o           (rnw_o),
    .in_msg_o        (in_msg_o)
  );
endmodule

// File: rtl/i3c_addr_ack_chk.sv
module i3c_addr_ack_chk
  import i3c_ack_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    i3c_mode_i,
  input logic    sda_oe_o,
  input logic    match_o,
  input logic    rnw_o,
  input logic    in_msg_o,
  input ack_st_e st_w,
  input logic    scl_rise_w,
  input logic    scl_fall_w,
  input logic    start_w,
  input logic    stop_w
);
  a_r6_oe_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> match_o);

  a_r1_cond_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_w, stop_w}));

  a_r1_start_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && !stop_w) |=> (in_msg_o && !match_o && !sda_oe_o));

  a_r2_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (!in_msg_o && !match_o && !sda_oe_o));

  a_r8_i3c_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_rise_w && st_w == ST_ACK_DRV && !start_w && !stop_w && i3c_mode_i && !rnw_o)
      |=> !sda_oe_o);

  a_r9_legacy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_rise_w && st_w == ST_ACK_DRV && !start_w && !stop_w && !i3c_mode_i && match_o)
      |=> sda_oe_o);

  a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_rise_w && st_w == ST_ACK_DRV && !start_w && !stop_w && rnw_o && match_o)
      |=> sda_oe_o);

  a_r12_release_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_w && st_w == ST_ACK_HIGH) |=> !sda_oe_o);
endmodule

bind i3c_addr_ack i3c_addr_ack_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .i3c_mode_i(i3c_mode_i),
  .sda_oe_o  (sda_oe_o),
  .match_o   (match_o),
  .rnw_o     (rnw_o),
  .in_msg_o  (in_msg_o),
  .st_w      (st_w),
  .scl_rise_w(scl_rise_w),
  .scl_fall_w(scl_fall_w),
  .start_w   (start_w),
  .stop_w    (stop_w)
);

// File: tb/i3c_addr_ack_tb_top.sv
module i3c_addr_ack_tb_top;
  localparam int Q = 6;  // quarter SCL period in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       ctrl_sda = 1'b1;
  logic [6:0] dyn_addr = 7'h2A;
  logic       dyn_valid = 1'b1;
  logic       mode = 1'b1;
  logic       sda_oe, match, rnw, in_msg;
  logic       sda_bus;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  assign sda_bus = ctrl_sda & ~sda_oe;  // open-drain wired line

  i3c_addr_ack dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .scl_i           (scl),
    .sda_i           (sda_bus),
    .dyn_addr_i      (dyn_addr),
    .dyn_addr_valid_i(dyn_valid),
    .i3c_mode_i      (mode),
    .sda_oe_o        (sda_oe),
    .match_o         (match),
    .rnw_o           (rnw),
    .in_msg_o        (in_msg)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      ctrl_sda = 1'b1; waitc(Q);
      scl = 1'b1;      waitc(Q);
    end
    ctrl_sda = 1'b0; waitc(2*Q);
    chk(in_msg == 1'b1, "R1 in_msg after START", in_msg, 1);
    chk(match == 1'b0, "R1 match cleared by START", match, 0);
    scl = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    ctrl_sda = 1'b0; waitc(Q);
    scl = 1'b1;      waitc(Q);
    ctrl_sda = 1'b1; waitc(Q);
    chk(in_msg == 1'b0, "R2 in_msg after STOP", in_msg, 0);
    chk(match == 1'b0, "R2 match after STOP", match, 0);
    chk(sda_oe == 1'b0, "R2 oe after STOP", sda_oe, 0);
  endtask

  // address + ack bit; SCL is low on entry and on exit
  task automatic frame(input logic [6:0] a, input logic rd);
    logic [7:0] byt;
    logic       exp_ack, exp_hold, oe_seen;
    byt      = {a, rd};
    exp_ack  = (a == 7'h7E) || (dyn_valid && a == dyn_addr);
    exp_hold = exp_ack && (rd || !mode);
    oe_seen  = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      ctrl_sda = byt[i]; waitc(Q);
      scl = 1'b1;
      for (int k = 0; k < 2*Q; k++) begin waitc(1); oe_seen |= sda_oe; end
      scl = 1'b0; waitc(Q);
    end
    chk(oe_seen == 1'b0, "R6 no drive during address", oe_seen, 0);
    ctrl_sda = 1'b1; waitc(Q);
    chk(match == exp_ack, "R4/R5 match decision", match, exp_ack);
    chk(rnw == rd, "R3 rnw latched", rnw, rd);
    if (exp_ack) chk(sda_oe == 1'b1, "R7 ack drive while SCL low", sda_oe, 1);
    else         chk(sda_oe == 1'b0, "R6 nack leaves SDA free", sda_oe, 0);
    scl = 1'b1;
    if (exp_ack && mode && !rd) ctrl_sda = 1'b0;  // controller takes over
    waitc(4);
    if (exp_hold) chk(sda_oe == 1'b1, "R9/R10 hold past SCL rise", sda_oe, 1);
    else          chk(sda_oe == 1'b0, "R8 release on SCL rise", sda_oe, 0);
    waitc(2*Q - 5);
    if (exp_hold) chk(sda_oe == 1'b1, "R9/R10 hold to end of high", sda_oe, 1);
    chk(in_msg == 1'b1, "R11 overlap is not STOP", in_msg, 1);
    scl = 1'b0; waitc(4);
    chk(sda_oe == 1'b0, "R12 release after SCL fall", sda_oe, 0);
    waitc(Q - 4);
  endtask

  initial begin
    waitc(3);
    chk(sda_oe == 0 && match == 0 && in_msg == 0, "R2 reset state",
        {sda_oe, match, in_msg}, 0);
    rst_n = 1'b1;
    waitc(4);
    // sweep every address; direction and mode from address bits
    for (int a = 0; a < 128; a++) begin
      mode = a[1];
      bus_start();
      frame(7'(a), a[0] ^ a[3]);
      bus_stop();
    end
    // targeted: broadcast, own, neighbour over rnw/mode/valid
    for (int t = 0; t < 24; t++) begin
      logic [6:0] ad;
      ad = (t / 8 == 0) ? 7'h7E : (t / 8 == 1) ? 7'h2A : 7'h2B;
      dyn_valid = t[2];
      mode      = t[1];
      bus_start();
      frame(ad, t[0]);
      bus_stop();
    end
    // repeated START between frames, no STOP in between
    dyn_valid = 1'b1; mode = 1'b1;
    bus_start();
    frame(7'h7E, 1'b0);
    bus_start();
    frame(7'h2A, 1'b1);
    bus_start();
    frame(7'h11, 1'b0);
    bus_stop();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule